// File: doc/BRIEF.md
# Dual-Region Read Address Pointer

This block holds the word-address counter that a serial memory slave uses for two regions. One region is the main byte array. The other is a 32-byte extended region: a 16-byte read-only serial number followed by 16 zero bytes. A transaction controller loads the pointer from the word-address bytes of a dummy write and pulses an increment strobe after every data byte it moves. It also drives a level flag that names the region the current transaction addresses. The pointer keeps its value between transactions, so a read that has no address phase continues from the last location accessed plus one.

The block chooses the wrap rule from the registered region and from the direction flag:
- A read in the array wraps at the end of the whole array.
- A write in the array wraps inside its 32-byte page.
- An access in the extended region wraps inside its 32 bytes.

The block also drives the read-data multiplexer select and the byte itself. That byte is the array data passed through, a serial-number byte taken from a parameter, a zero byte, or FFh when the extended-region code bits hold an invalid code.

The block has two state machines:
- Region machine. State RGN_ARRAY is entered at reset and on any edge where `ext_i` is low. State RGN_EXT is entered on any edge where `ext_i` is high.
- Select decode. It picks one of SEL_ARRAY, SEL_SERIAL, SEL_ZERO or SEL_BAD from the region state and the pointer.

The pointer register has three transitions: load, step and hold.

Top module: `dual_region_ptr`

## Requirements
- R1: After reset the pointer is 0 and the region is the array: `arr_addr_o` = 0, `rd_sel_o` = 0, `rd_byte_o` = `arr_rdata_i`.
- R2: When `load_i` is high at a clock edge, the pointer takes `load_addr_i[12:0]`. This applies even if `incr_i` is also high at that edge.
- R3: With neither `load_i` nor `incr_i` high, the pointer keeps its value.
- R4: In the array region with `wr_i` = 0, `incr_i` adds one to the pointer modulo 8192, so 1FFFh steps to 0000h.
- R5: In the array region with `wr_i` = 1, `incr_i` adds one to bits 4:0 only, modulo 32. Bits 12:5 stay unchanged, so 0A3Fh steps to 0A20h.
- R6: In the extended region, `incr_i` adds one to bits 4:0 modulo 32 whatever the value of `wr_i`. Bits 12:5 stay unchanged.
- R7: In the extended region with pointer bits 11:10 = 10b and offset n < 16, `rd_sel_o` = 1 and `rd_byte_o` = `SERIAL[8n+7:8n]`.
- R8: In the extended region with bits 11:10 = 10b and offset 16 to 31, `rd_sel_o` = 2 and `rd_byte_o` = 00h.
- R9: In the extended region with bits 11:10 not equal to 10b, `rd_sel_o` = 3 and `rd_byte_o` = FFh.
- R10: One pointer serves both regions. `ext_off_o` is always pointer bits 4:0, and a switch of region keeps the position the last array access left.
- R11: In the array region, `rd_sel_o` = 0, `rd_byte_o` follows `arr_rdata_i`, and `arr_addr_o` equals the pointer.
- R12: The region is the value of `ext_i` registered at each clock edge (0 = array, 1 = extended). The wrap rule and the output select follow the registered region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load the pointer from `load_addr_i` |
| load_addr_i | input | 16 | Word address from the two address bytes |
| incr_i | input | 1 | One data byte moved; step the pointer |
| ext_i | input | 1 | Region flag: 1 = extended region |
| wr_i | input | 1 | Direction flag: 1 = write transaction |
| arr_rdata_i | input | 8 | Byte read from the main array |
| arr_addr_o | output | 13 | Pointer, used as the array address |
| ext_off_o | output | 5 | Extended-region offset |
| rd_sel_o | output | 2 | Read mux select: 0 array, 1 serial, 2 zero, 3 invalid |
| rd_byte_o | output | 8 | Byte to shift out |

## Verification
The assertions check the per-cycle rules on every clock: hold, load, the page-bounded and region-bounded steps that keep bits 12:5, and the forced zero and FFh bytes. Only the bench scenarios show the properties that span many bytes. These are the full-array wrap from 1FFFh, the return of a 32-byte sweep to offset 0, and the serial-byte order against the parameter. They also include the way an array access leaves a position that a later extended read picks up.

// File: rtl/dual_region_ptr_pkg.sv
package dual_region_ptr_pkg;
    typedef enum logic {
        RGN_ARRAY = 1'b0,
        RGN_EXT   = 1'b1
    } region_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_SERIAL = 2'd1,
        SEL_ZERO   = 2'd2,
        SEL_BAD    = 2'd3
    } rsel_e;
endpackage

// File: rtl/ptr_step.sv
module ptr_step #(
    parameter int ADDR_W = 13,
    parameter int WRAP_W = 5
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              full_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic [WRAP_W-1:0] low_inc;

    always_comb begin
        low_inc = cur_i[WRAP_W-1:0] + WRAP_W'(1);
        if (full_i)
            nxt_o = cur_i + ADDR_W'(1);
        else
            nxt_o = {cur_i[ADDR_W-1:WRAP_W], low_inc};
    end
endmodule

// File: rtl/ext_rom.sv
module ext_rom
    import dual_region_ptr_pkg::*;
#(
    parameter int           EXT_W    = 5,
    parameter int           SN_BYTES = 16,
    parameter logic [SN_BYTES*8-1:0] SERIAL = '0
) (
    input  logic [EXT_W-1:0] off_i,
    input  logic             code_ok_i,
    output rsel_e            sel_o,
    output logic [7:0]       byte_o
);
    localparam int SN_IDX_W = $clog2(SN_BYTES);

    logic [7:0] sn_tbl [SN_BYTES];

    for (genvar k = 0; k < SN_BYTES; k++) begin : g_tbl
        assign sn_tbl[k] = SERIAL[8*k +: 8];
    end

    always_comb begin
        if (!code_ok_i)
            sel_o = SEL_BAD;
        else if (int'(off_i) < SN_BYTES)
            sel_o = SEL_SERIAL;
        else
            sel_o = SEL_ZERO;
    end

    always_comb begin
        unique case (sel_o)
            SEL_SERIAL: byte_o = sn_tbl[off_i[SN_IDX_W-1:0]];
            SEL_ZERO:   byte_o = 8'h00;
            SEL_BAD:    byte_o = 8'hFF;
            default:    byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/dual_region_ptr.sv
module dual_region_ptr
    import dual_region_ptr_pkg::*;
#(
    parameter int LOAD_W   = 16,
    parameter int ADDR_W   = 13,
    parameter int PAGE_W   = 5,
    parameter int EXT_W    = 5,
    parameter int SN_BYTES = 16,
    parameter int CODE_LO  = 10,
    parameter logic [1:0] EXT_CODE = 2'b10,
    parameter logic [SN_BYTES*8-1:0] SERIAL = 128'h8F7E6D5C4B3A29180716253443526170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LOAD_W-1:0] load_addr_i,
    input  logic              incr_i,
    input  logic              ext_i,
    input  logic              wr_i,
    input  logic [7:0]        arr_rdata_i,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [EXT_W-1:0]  ext_off_o,
    output logic [1:0]        rd_sel_o,
    output logic [7:0]        rd_byte_o
);
    region_e           rgn_q, rgn_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [ADDR_W-1:0] page_nxt, ext_nxt, step_nxt;
    logic              code_ok;
    rsel_e             rom_sel, sel;
    logic [7:0]        rom_byte;
    logic              unused_hi;

    assign unused_hi = ^load_addr_i[LOAD_W-1:ADDR_W];

    ptr_step #(.ADDR_W(ADDR_W), .WRAP_W(PAGE_W)) u_page_step (
        .cur_i (ptr_q),
        .full_i(~wr_i),
        .nxt_o (page_nxt)
    );

    ptr_step #(.ADDR_W(ADDR_W), .WRAP_W(EXT_W)) u_ext_step (
        .cur_i (ptr_q),
        .full_i(1'b0),
        .nxt_o (ext_nxt)
    );

    assign code_ok = (ptr_q[CODE_LO+1:CODE_LO] == EXT_CODE);

    ext_rom #(.EXT_W(EXT_W), .SN_BYTES(SN_BYTES), .SERIAL(SERIAL)) u_rom (
        .off_i    (ptr_q[EXT_W-1:0]),
        .code_ok_i(code_ok),
        .sel_o    (rom_sel),
        .byte_o   (rom_byte)
    );

    // next region and next pointer
    always_comb begin
        rgn_d = ext_i ? RGN_EXT : RGN_ARRAY;
        unique case (rgn_q)
            RGN_ARRAY: step_nxt = page_nxt;
            RGN_EXT:   step_nxt = ext_nxt;
            default:   step_nxt = page_nxt;
        endcase
        if (load_i)
            ptr_d = load_addr_i[ADDR_W-1:0];
        else if (incr_i)
            ptr_d = step_nxt;
        else
            ptr_d = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_q <= RGN_ARRAY;
            ptr_q <= '0;
        end else begin
            rgn_q <= rgn_d;
            ptr_q <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        unique case (rgn_q)
            RGN_ARRAY: begin
                sel       = SEL_ARRAY;
                rd_byte_o = arr_rdata_i;
            end
            RGN_EXT: begin
                sel       = rom_sel;
                rd_byte_o = rom_byte;
            end
            default: begin
                sel       = SEL_ARRAY;
                rd_byte_o = arr_rdata_i;
            end
        endcase
        rd_sel_o   = sel;
        arr_addr_o = ptr_q;
        ext_off_o  = ptr_q[EXT_W-1:0];
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !incr_i) |=> $stable(arr_addr_o)) else $error("hold"); // R3
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (arr_addr_o == $past(load_addr_i[ADDR_W-1:0]))) else $error("load"); // R2
    AST_BOUNDED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && incr_i && (wr_i || rgn_q == RGN_EXT))
        |=> (arr_addr_o[ADDR_W-1:PAGE_W] == $past(arr_addr_o[ADDR_W-1:PAGE_W]))) else $error("bound"); // R5
    AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_q == RGN_EXT && code_ok && ext_off_o >= EXT_W'(SN_BYTES)) |-> (rd_byte_o == 8'h00)) else $error("zero"); // R8
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_q == RGN_EXT && !code_ok) |-> (rd_byte_o == 8'hFF && rd_sel_o == 2'd3)) else $error("bad"); // R9
    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_q == RGN_ARRAY) |-> (rd_byte_o == arr_rdata_i)) else $error("pass"); // R11
endmodule

// File: tb/dual_region_ptr_tb.sv
`timescale 1ns/1ps
module dual_region_ptr_tb_top;
    localparam logic [127:0] SN = 128'h8F7E6D5C4B3A29180716253443526170;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_addr_i = '0;
    logic        incr_i = 1'b0;
    logic        ext_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  arr_rdata_i = 8'h5A;
    logic [12:0] arr_addr_o;
    logic [4:0]  ext_off_o;
    logic [1:0]  rd_sel_o;
    logic [7:0]  rd_byte_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [12:0] ptr_m;
    logic        rgn_m;

    always #5 clk = ~clk;

    dual_region_ptr #(.SERIAL(SN)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
        .incr_i(incr_i), .ext_i(ext_i), .wr_i(wr_i), .arr_rdata_i(arr_rdata_i),
        .arr_addr_o(arr_addr_o), .ext_off_o(ext_off_o), .rd_sel_o(rd_sel_o),
        .rd_byte_o(rd_byte_o)
    );

    function automatic logic [12:0] m_next(logic [12:0] p, logic rg, logic wr);
        if (rg || wr) return {p[12:5], p[4:0] + 5'd1};
        return p + 13'd1;
    endfunction

    function automatic logic [7:0] m_byte(logic [12:0] p, logic rg, logic [7:0] rd);
        if (!rg) return rd;
        if (p[11:10] != 2'b10) return 8'hFF;
        if (p[4:0] < 5'd16) return SN[8*p[3:0] +: 8];
        return 8'h00;
    endfunction

    function automatic logic [1:0] m_sel(logic [12:0] p, logic rg);
        if (!rg) return 2'd0;
        if (p[11:10] != 2'b10) return 2'd3;
        if (p[4:0] < 5'd16) return 2'd1;
        return 2'd2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ptr_m <= '0;
            rgn_m <= 1'b0;
        end else begin
            rgn_m <= ext_i;
            if (load_i) ptr_m <= load_addr_i[12:0];
            else if (incr_i) ptr_m <= m_next(ptr_m, rgn_m, wr_i);
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(logic ld, logic [15:0] a, logic inc, logic ex, logic wr, logic [7:0] rd);
        load_i = ld; load_addr_i = a; incr_i = inc; ext_i = ex; wr_i = wr; arr_rdata_i = rd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_model(string req);
        chk({req, " addr"}, 32'(arr_addr_o), 32'(ptr_m));
        chk({req, " off"},  32'(ext_off_o), 32'(ptr_m[4:0]));
        chk({req, " sel"},  32'(rd_sel_o), 32'(m_sel(ptr_m, rgn_m)));
        chk({req, " byte"}, 32'(rd_byte_o), 32'(m_byte(ptr_m, rgn_m, arr_rdata_i)));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 addr", 32'(arr_addr_o), 0);
        chk("R1 sel", 32'(rd_sel_o), 0);
        chk("R1 byte", 32'(rd_byte_o), 32'h5A);

        step(1, 16'hE000 | 16'h1FFF, 0, 0, 0, 8'h11);
        chk("R2 load", 32'(arr_addr_o), 32'h1FFF);
        step(0, 0, 1, 0, 0, 8'h11);
        chk("R4 array wrap", 32'(arr_addr_o), 0);

        step(1, 16'h0A3F, 0, 0, 1, 8'h11);
        step(0, 0, 1, 0, 1, 8'h11);
        chk("R5 page wrap", 32'(arr_addr_o), 32'h0A20);
        step(0, 0, 0, 0, 0, 8'h11);
        step(0, 0, 0, 0, 0, 8'h11);
        chk("R3 hold", 32'(arr_addr_o), 32'h0A20);
        step(1, 16'h0123, 1, 0, 0, 8'h11);
        chk("R2 load over incr", 32'(arr_addr_o), 32'h0123);

        step(1, 16'h0800, 0, 1, 0, 8'h22);
        for (int k = 0; k < 32; k++) begin
            if (k < 16) begin
                chk("R7 serial sel", 32'(rd_sel_o), 1);
                chk("R7 serial byte", 32'(rd_byte_o), 32'(SN[8*k +: 8]));
            end else begin
                chk("R8 zero sel", 32'(rd_sel_o), 2);
                chk("R8 zero byte", 32'(rd_byte_o), 0);
            end
            step(0, 0, 1, 1, 0, 8'h22);
        end
        chk("R6 ext wrap", 32'(arr_addr_o), 32'h0800);

        step(1, 16'h0C03, 0, 1, 0, 8'h22);
        chk("R9 bad sel", 32'(rd_sel_o), 3);
        chk("R9 bad byte", 32'(rd_byte_o), 32'hFF);

        step(1, 16'h0805, 0, 0, 0, 8'h33);
        step(0, 0, 1, 0, 0, 8'h33);
        step(0, 0, 0, 1, 0, 8'h33);
        chk("R12 region follows flag", 32'(rd_sel_o), 1);
        chk("R10 shared offset", 32'(ext_off_o), 6);
        chk("R10 shared byte", 32'(rd_byte_o), 32'(SN[8*6 +: 8]));

        step(0, 0, 0, 0, 0, 8'hC3);
        chk("R11 pass sel", 32'(rd_sel_o), 0);
        chk("R11 pass byte", 32'(rd_byte_o), 32'hC3);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom % 2 == 0) a[11:10] = 2'b10;
            if ($urandom % 8 == 0) a[12:0] = ($urandom % 2 == 0) ? 13'h1FFF : 13'h0BFF;
            step(($urandom % 10) == 0, a, ($urandom % 3) != 0,
                 ($urandom % 3) == 0, ($urandom % 4) == 0, 8'($urandom));
            chk_model("R12 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule